// File: doc/BRIEF.md
# Snooping Bank Selector for a Banked Program ROM

A plug-in program memory can hold several banks of code behind each 4K-word page of the processor's address space. This block decides which bank each page pair presents. It watches the 10-bit words the memory itself returns on instruction fetches and reacts to a small set of bank-select opcodes. The 16-bit fetch address carries the page number in its top nibble.

The high pages are grouped in pairs: 8-9, A-B, C-D and E-F. A bank-select opcode fetched from either page of a pair switches that pair. A mode input widens the switch to every pair at once. A select opcode is obeyed only if the word fetched just before it, from this memory, had bit 9 clear. A power-off opcode sends every pair back to the first bank. Fetches answered by other memories never change the banks. They also clear the qualifying flag.

Each pair's bank index is registered. It updates on the clock edge that samples the qualifying fetch, so the next fetch already reads the new bank. The ROM array uses the indices as upper address bits.

Top module: `rom_bank_switch`

## Requirements
- R1: While `rst` is high at a clock edge, every pair's index becomes 0, where index k means bank k+1. Pair g occupies `bank_idx[2g+1:2g]`: pair 0 is pages 8-9, pair 1 is A-B, pair 2 is C-D and pair 3 is E-F. The qualifying flag is also cleared, so the first fetch after reset cannot enable a switch.
- R2: Words 0x100, 0x180, 0x140 and 0x1C0 select banks 1, 2, 3 and 4 (indices 0 to 3). The new index appears on the clock edge that samples the fetch, and not before that edge.
- R3: A select opcode is obeyed only when the previous fetch answered by this memory returned a word with bit 9 clear. Otherwise it is ignored.
- R4: A fetch with `fetch_hit` low never changes any index, even if its word is a select opcode. It also clears the qualifying flag.
- R5: With `mode_all_pages` low, an obeyed select changes only the pair that holds the fetch page. Both pages of a pair act on that same pair.
- R6: With `mode_all_pages` low, select opcodes fetched from pages 0 to 7 change nothing.
- R7: With `mode_all_pages` high, an obeyed select fetched from any page changes every pair that has the requested bank fitted.
- R8: A request for a bank beyond a pair's fitted count leaves that pair unchanged. By default pair 1 has 2 banks fitted and the other pairs have 4.
- R9: Word 0x060 fetched with `fetch_hit` high sets every index to 0, whatever the previous word was.
- R10: Cycles with `fetch_vld` low change neither the indices nor the qualifying flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_all_pages | input | 1 | 1: a select switches every pair; 0: only the issuing pair |
| fetch_vld | input | 1 | Instruction fetch strobe for this cycle |
| fetch_addr | input | 16 | Fetch address; bits 15:12 are the page |
| fetch_word | input | 10 | Instruction word on the fetch |
| fetch_hit | input | 1 | This memory answered the fetch |
| bank_idx | output | 8 | Registered bank index, 2 bits per page pair |

## Verification
The assertions assume that `fetch_word` is only meaningful while `fetch_vld` is high. They also assume that `fetch_hit` only matters together with `fetch_vld`, and that `mode_all_pages` holds steady around a fetch. The stimulus changes every input only on the falling edge, so the value sampled at each rising edge is settled. It also sets the mode only in vectors where it is meant to apply. Foreign fetches are given select opcode words on purpose, so that the rule "ignore what this memory did not supply" is exercised rather than assumed.

// File: rtl/bsw_pkg.sv
package bsw_pkg;

    localparam int WORD_W    = 10;
    localparam int ADDR_W    = 16;
    localparam int PAGE_W    = 4;
    localparam int MAX_BANKS = 4;
    localparam int BANK_W    = $clog2(MAX_BANKS);

    typedef logic [BANK_W-1:0] bank_t;
    typedef logic [WORD_W-1:0] word_t;

    // decoded meaning of one fetched word
    typedef struct packed {
        logic  sel;   // one of the bank-select opcodes
        bank_t req;   // requested bank index
        logic  off;   // power-off opcode
    } op_t;

    function automatic logic [PAGE_W-1:0] page_of(input logic [ADDR_W-1:0] a);
        return a[ADDR_W-1 -: PAGE_W];
    endfunction

endpackage

// File: rtl/bsw_decode.sv
module bsw_decode
    import bsw_pkg::*;
#(
    parameter logic [MAX_BANKS*WORD_W-1:0] OP_SEL = {10'h1C0, 10'h140, 10'h180, 10'h100},
    parameter logic [WORD_W-1:0]           OP_OFF = 10'h060
) (
    input  word_t word,
    output op_t   op
);
    logic [MAX_BANKS-1:0] match;

    for (genvar i = 0; i < MAX_BANKS; i++) begin : g_match
        assign match[i] = (word == OP_SEL[i*WORD_W +: WORD_W]);
    end

    always_comb begin
        op     = '0;
        op.off = (word == OP_OFF);
        for (int i = 0; i < MAX_BANKS; i++) begin
            if (match[i]) begin
                op.sel = 1'b1;
                op.req = bank_t'(i);
            end
        end
    end

    // R2: distinct opcode encodings never match together
    always_comb begin
        a_onehot_sel_r2: assert ($onehot0(match));
    end
endmodule

// File: rtl/bsw_qualify.sv
module bsw_qualify
    import bsw_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  vld,
    input  logic  hit,
    input  word_t word,
    output logic  armed
);
    always_ff @(posedge clk) begin
        if (rst)
            armed <= 1'b0;
        else if (vld)
            armed <= hit & ~word[WORD_W-1];
    end

    // R4: a foreign fetch leaves the memory unarmed
    p_foreign_clears_r4: assert property (@(posedge clk) disable iff (rst)
        (vld && !hit) |=> !armed);
    // R3: arming comes only from an own fetch with bit 9 clear
    p_arm_source_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(armed) |-> $past(vld && hit && !word[WORD_W-1]));
    // R10: idle cycles keep the flag
    p_idle_holds_r10: assert property (@(posedge clk) disable iff (rst)
        !vld |=> $stable(armed));
endmodule

// File: rtl/bsw_group.sv
module bsw_group
    import bsw_pkg::*;
#(
    parameter logic [3:0] FIT = 4'd4
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  take,
    input  bank_t req,
    input  logic  off,
    output bank_t bank
);
    logic fitted;
    assign fitted = ({2'b00, req} < FIT);

    always_ff @(posedge clk) begin
        if (rst || off)
            bank <= '0;
        else if (take && fitted)
            bank <= req;
    end

    // R9: power-off returns the pair to the first bank
    p_off_home_r9: assert property (@(posedge clk) disable iff (rst)
        off |=> (bank == '0));
    // R8: the index never names an unfitted bank
    p_fitted_r8: assert property (@(posedge clk) disable iff (rst)
        ({2'b00, bank} < FIT));
    // R5: without a command the pair holds its bank
    p_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (!take && !off) |=> $stable(bank));
endmodule

// File: rtl/rom_bank_switch.sv
module rom_bank_switch
    import bsw_pkg::*;
#(
    parameter int                          BASE_PAGE    = 8,
    parameter logic [MAX_BANKS*WORD_W-1:0] OP_SEL       = {10'h1C0, 10'h140, 10'h180, 10'h100},
    parameter logic [WORD_W-1:0]           OP_OFF       = 10'h060,
    parameter logic [4*((16-BASE_PAGE)/2)-1:0] FITTED_BANKS = {4'd4, 4'd4, 4'd2, 4'd4}
) (
    input  logic                                  clk,
    input  logic                                  rst,
    input  logic                                  mode_all_pages,
    input  logic                                  fetch_vld,
    input  logic [15:0]                           fetch_addr,
    input  logic [9:0]                            fetch_word,
    input  logic                                  fetch_hit,
    output logic [BANK_W*((16-BASE_PAGE)/2)-1:0]  bank_idx
);
    localparam int NUM_GROUPS = (16 - BASE_PAGE) / 2;

    op_t                   op;
    logic                  armed;
    logic                  own_fetch;
    logic                  ev_sel;
    logic                  ev_off;
    logic [PAGE_W-1:0]     page;
    logic [NUM_GROUPS-1:0] mine;
    logic [11:0]           addr_low_unused;

    assign addr_low_unused = fetch_addr[11:0];
    assign page      = page_of(fetch_addr);
    assign own_fetch = fetch_vld & fetch_hit;
    assign ev_sel    = own_fetch & op.sel & armed;
    assign ev_off    = own_fetch & op.off;

    bsw_decode #(.OP_SEL(OP_SEL), .OP_OFF(OP_OFF)) u_dec (
        .word (fetch_word),
        .op   (op)
    );

    bsw_qualify u_qual (
        .clk   (clk),
        .rst   (rst),
        .vld   (fetch_vld),
        .hit   (fetch_hit),
        .word  (fetch_word),
        .armed (armed)
    );

    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_pair
        localparam logic [PAGE_W-2:0] PAIR = (PAGE_W-1)'(BASE_PAGE/2 + g);
        bank_t bank;

        assign mine[g] = (page[PAGE_W-1:1] == PAIR);

        bsw_group #(.FIT(FITTED_BANKS[4*g +: 4])) u_grp (
            .clk  (clk),
            .rst  (rst),
            .take (ev_sel & (mode_all_pages | mine[g])),
            .req  (op.req),
            .off  (ev_off),
            .bank (bank)
        );

        assign bank_idx[BANK_W*g +: BANK_W] = bank;
    end

    // R4 / R10: nothing but an own fetch can move any bank
    p_only_own_fetch_r4: assert property (@(posedge clk) disable iff (rst)
        !own_fetch |=> $stable(bank_idx));
    // R3: an opcode after an unqualified word leaves all banks in place
    p_unarmed_ignored_r3: assert property (@(posedge clk) disable iff (rst)
        (own_fetch && !armed && !op.off) |=> $stable(bank_idx));
endmodule

// File: tb/sim_rom_bank_switch.sv
module sim_rom_bank_switch;
    localparam int PERIOD = 10;
    localparam int NV     = 32;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       mode_all_pages = 1'b0;
    logic       fetch_vld = 1'b0;
    logic [15:0] fetch_addr = '0;
    logic [9:0] fetch_word = '0;
    logic       fetch_hit = 1'b0;
    logic [7:0] bank_idx;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;

    always #(PERIOD/2) clk = ~clk;

    rom_bank_switch u0 (
        .clk            (clk),
        .rst            (rst),
        .mode_all_pages (mode_all_pages),
        .fetch_vld      (fetch_vld),
        .fetch_addr     (fetch_addr),
        .fetch_word     (fetch_word),
        .fetch_hit      (fetch_hit),
        .bank_idx       (bank_idx)
    );

    typedef struct packed {
        logic       r;
        logic       glob;
        logic       vld;
        logic       hit;
        logic [3:0] page;
        logic [9:0] word;
        logic [7:0] exp;
        logic [3:0] req;
    } vec_t;

    // words: NOP 000, HI 200, B1 100, B2 180, B3 140, B4 1C0, OFF 060
    localparam vec_t VEC [NV] = '{
        '{1'b1,1'b0,1'b0,1'b0,4'h0,10'h000,8'h00,4'd1},  // R1 reset
        '{1'b0,1'b0,1'b1,1'b1,4'h8,10'h000,8'h00,4'd3},  // arm
        '{1'b0,1'b0,1'b1,1'b1,4'h8,10'h180,8'h01,4'd2},  // R2 bank 2
        '{1'b0,1'b0,1'b1,1'b1,4'h8,10'h1C0,8'h03,4'd2},  // R2 bank 4
        '{1'b0,1'b0,1'b1,1'b1,4'h9,10'h140,8'h02,4'd5},  // R5 page 9
        '{1'b0,1'b0,1'b1,1'b1,4'hC,10'h200,8'h02,4'd3},  // bit 9 set
        '{1'b0,1'b0,1'b1,1'b1,4'hC,10'h180,8'h02,4'd3},  // R3 ignored
        '{1'b0,1'b0,1'b1,1'b1,4'hC,10'h000,8'h02,4'd3},
        '{1'b0,1'b0,1'b1,1'b1,4'hD,10'h180,8'h12,4'd5},  // R5 pair C-D
        '{1'b0,1'b0,1'b1,1'b0,4'hC,10'h000,8'h12,4'd4},  // R4 foreign
        '{1'b0,1'b0,1'b1,1'b1,4'hC,10'h140,8'h12,4'd4},  // R4 disarmed
        '{1'b0,1'b0,1'b1,1'b1,4'hE,10'h000,8'h12,4'd4},
        '{1'b0,1'b0,1'b1,1'b0,4'hE,10'h1C0,8'h12,4'd4},  // R4 foreign op
        '{1'b0,1'b0,1'b1,1'b1,4'hE,10'h000,8'h12,4'd10},
        '{1'b0,1'b0,1'b0,1'b0,4'hE,10'h000,8'h12,4'd10}, // R10 idle
        '{1'b0,1'b0,1'b0,1'b1,4'hE,10'h1C0,8'h12,4'd10}, // R10 no strobe
        '{1'b0,1'b0,1'b1,1'b1,4'hE,10'h1C0,8'hD2,4'd10}, // R10 flag kept
        '{1'b0,1'b0,1'b1,1'b1,4'h4,10'h000,8'hD2,4'd6},
        '{1'b0,1'b0,1'b1,1'b1,4'h4,10'h180,8'hD2,4'd6},  // R6 low page
        '{1'b0,1'b0,1'b1,1'b1,4'hA,10'h140,8'hD2,4'd8},  // R8 unfitted
        '{1'b0,1'b0,1'b1,1'b1,4'hB,10'h180,8'hD6,4'd8},  // R8 fitted
        '{1'b0,1'b0,1'b1,1'b1,4'hA,10'h1C0,8'hD6,4'd8},  // R8 unfitted
        '{1'b0,1'b0,1'b1,1'b1,4'hC,10'h200,8'hD6,4'd9},
        '{1'b0,1'b0,1'b1,1'b1,4'hC,10'h060,8'h00,4'd9},  // R9 off unarmed
        '{1'b0,1'b1,1'b1,1'b1,4'h8,10'h000,8'h00,4'd7},
        '{1'b0,1'b1,1'b1,1'b1,4'h8,10'h180,8'h55,4'd7},  // R7 all pairs
        '{1'b0,1'b1,1'b1,1'b1,4'hF,10'h140,8'hA6,4'd7},  // R7 pair 1 short
        '{1'b0,1'b1,1'b1,1'b1,4'h5,10'h1C0,8'hF7,4'd7},  // R7 low page
        '{1'b0,1'b0,1'b1,1'b1,4'hE,10'h060,8'h00,4'd9},  // R9 off
        '{1'b0,1'b0,1'b1,1'b1,4'h8,10'h180,8'h01,4'd9},  // off word arms
        '{1'b1,1'b0,1'b0,1'b0,4'h0,10'h000,8'h00,4'd1},  // R1 reset again
        '{1'b0,1'b0,1'b1,1'b1,4'h8,10'h180,8'h00,4'd1}   // R1 flag cleared
    };

    task automatic check(input logic [7:0] exp, input int req);
        checks++;
        if (bank_idx !== exp) begin
            errors++;
            $display("FAIL R%0d: bank_idx got %h expected %h", req, bank_idx, exp);
        end
    endtask

    task automatic drive(input logic r, input logic glob, input logic vld,
                         input logic hit, input logic [3:0] page, input logic [9:0] word);
        rst            = r;
        mode_all_pages = glob;
        fetch_vld      = vld;
        fetch_hit      = hit;
        fetch_addr     = {page, 12'h3A5};
        fetch_word     = word;
    endtask

    initial begin
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            drive(VEC[i].r, VEC[i].glob, VEC[i].vld, VEC[i].hit, VEC[i].page, VEC[i].word);
            @(posedge clk);
            #1;
            check(VEC[i].exp, int'(VEC[i].req));
        end

        // R2 timing: old bank before the edge, new bank right after it
        @(negedge clk);
        drive(1'b0, 1'b0, 1'b1, 1'b1, 4'h8, 10'h000);
        @(negedge clk);
        drive(1'b0, 1'b0, 1'b1, 1'b1, 4'h8, 10'h1C0);
        #1;
        check(8'h00, 2);
        @(posedge clk);
        #1;
        check(8'h03, 2);

        // R9: off from pair E-F also clears pair 8-9
        @(negedge clk);
        drive(1'b0, 1'b0, 1'b1, 1'b1, 4'hF, 10'h060);
        @(posedge clk);
        #1;
        check(8'h00, 9);

        @(negedge clk);
        drive(1'b0, 1'b0, 1'b0, 1'b0, 4'h0, 10'h000);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(PERIOD * 5000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: run got hung expected finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule